// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block times a single conversion of a successive-approximation ADC. A start comes from a software strobe or from a rising edge on one of several external event lines. The regular group and the injected group each pick their own event line. On a start the block latches the group, the channel and the alignment. It then holds a sample phase whose length comes from that channel's 3-bit sample-time code, followed by a fixed conversion phase of 12.5 ADC clock cycles. At the end it captures the 12-bit result from the analog model and formats it into a 16-bit word. A one-cycle end-of-conversion strobe marks the new word.

The block runs on a clock at twice the ADC clock rate, so every count is in half ADC cycles and the x.5 durations are exact. The sample-time codes are supplied as a packed vector with one 3-bit field per channel. Event lines are asynchronous and pass through a two-stage synchroniser before edge detection.

Top module: `adc_conv_sequencer`

## Requirements
- R1: Channel c's sample-time code is field `smp_codes[3c+2:3c]`. Codes 0..7 give a sample phase (`sampling` high) of 3, 15, 27, 57, 83, 111, 143 and 479 clock cycles (1.5 to 239.5 ADC cycles).
- R2: `converting` is high for exactly 25 clock cycles right after the sample phase ends, and `eoc` rises in the cycle after `converting` falls. Code 0 therefore gives 28 clock cycles, which is 14 ADC cycles, from start to `eoc`.
- R3: While `ext_trig_en` is low, no event line starts a conversion.
- R4: A rising edge on `evt_in[reg_sel]` starts a regular conversion, and one on `evt_in[inj_sel]` starts an injected one (`conv_inj` = 1). `sampling` goes high after the third rising clock edge that follows the line rising.
- R5: An event line held high starts only one conversion, and a falling edge starts none.
- R6: While `busy` is high, triggers of any kind are dropped and not queued, and `conv_ch` holds its value.
- R7: Regular group, right alignment (`align_left`=0): `data_out` = {4'b0, result}.
- R8: Regular group, left alignment: `data_out` = {result, 4'b0}.
- R9: Injected group, right alignment: `data_out` = {4 copies of result[11], result}.
- R10: Injected group, left alignment: `data_out` = {result[11], result, 3'b0}.
- R11: `eoc` is high for exactly one cycle, and `data_out` keeps its value until the next `eoc`.
- R12: `sw_start_reg` and `sw_start_inj` start a conversion in the cycle after the strobe while idle. If both start requests arrive together, the injected group wins.
- R13: During reset and right after it, `busy`, `sampling`, `converting`, `eoc` and `data_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the ADC clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_codes | input | NUM_CH*3 | Per-channel 3-bit sample-time codes |
| ext_trig_en | input | 1 | Lets event lines start conversions |
| reg_sel | input | SEL_W | Event line for the regular group |
| inj_sel | input | SEL_W | Event line for the injected group |
| evt_in | input | NUM_EVT | Asynchronous external event lines |
| sw_start_reg | input | 1 | Software start, regular group |
| sw_start_inj | input | 1 | Software start, injected group |
| ch_reg | input | CH_W | Channel used for a regular conversion |
| ch_inj | input | CH_W | Channel used for an injected conversion |
| align_left | input | 1 | 1 selects left alignment |
| result_in | input | RES_W | Raw result from the analog model |
| busy | output | 1 | Conversion in progress |
| sampling | output | 1 | Sample phase active |
| converting | output | 1 | Conversion phase active |
| conv_ch | output | CH_W | Channel of the current or last conversion |
| conv_inj | output | 1 | Current or last conversion is injected |
| eoc | output | 1 | One-cycle end-of-conversion strobe |
| data_out | output | OUT_W | Formatted result word |

## Verification
The bench uses the default parameters: eight channels, eight event lines, a 12-bit result in a 16-bit word and two synchroniser stages. With these values all eight sample-time codes, including the 479-cycle longest phase, run to completion within the cycle limit. Each code is paired with a different group and alignment, and the results are chosen to place a set or clear sign bit in every format. With eight event lines the two selectors can point at different lines, so the bench checks that the groups trigger independently and measures the three-edge synchroniser latency exactly.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_CONV   = 2'd2
    } seq_state_e;

    localparam int SMP_CODE_W = 3;

    // Sample phase length in half ADC-clock units for each 3-bit code
    function automatic int unsigned smp_half_cycles(input logic [SMP_CODE_W-1:0] code);
        case (code)
            3'd0:    return 3;
            3'd1:    return 15;
            3'd2:    return 27;
            3'd3:    return 57;
            3'd4:    return 83;
            3'd5:    return 111;
            3'd6:    return 143;
            default: return 479;
        endcase
    endfunction

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
    parameter int NUM_EVT     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic [NUM_EVT-1:0] rise
);

    // Per line: SYNC_STAGES synchroniser flops plus one history flop
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_line
        logic [SYNC_STAGES:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[SYNC_STAGES-1:0], evt_in[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign rise[g] = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    end

endmodule

// File: rtl/adc_smp_lut.sv
module adc_smp_lut
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic [SMP_CODE_W-1:0] code,
    output logic [CNT_W-1:0]      half_cnt
);

    always_comb begin
        half_cnt = CNT_W'(smp_half_cycles(code));
    end

endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
    parameter int RES_W = 12,
    parameter int OUT_W = 16
) (
    input  logic [RES_W-1:0] raw,
    input  logic             inj,
    input  logic             left,
    output logic [OUT_W-1:0] word
);

    localparam int PAD_W = OUT_W - RES_W;

    logic sgn;
    assign sgn = raw[RES_W-1];

    always_comb begin
        unique case ({inj, left})
            2'b00:   word = {{PAD_W{1'b0}}, raw};
            2'b01:   word = {raw, {PAD_W{1'b0}}};
            2'b10:   word = {{PAD_W{sgn}}, raw};
            default: word = {sgn, raw, {(PAD_W-1){1'b0}}};
        endcase
    end

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH       = 8,
    parameter int NUM_EVT      = 8,
    parameter int RES_W        = 12,
    parameter int OUT_W        = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int CONV_HALF    = 25,
    parameter int MAX_SMP_HALF = 479,
    localparam int CH_W  = (NUM_CH  > 1) ? $clog2(NUM_CH)  : 1,
    localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH*SMP_CODE_W-1:0] smp_codes,
    input  logic                       ext_trig_en,
    input  logic [SEL_W-1:0]           reg_sel,
    input  logic [SEL_W-1:0]           inj_sel,
    input  logic [NUM_EVT-1:0]         evt_in,
    input  logic                       sw_start_reg,
    input  logic                       sw_start_inj,
    input  logic [CH_W-1:0]            ch_reg,
    input  logic [CH_W-1:0]            ch_inj,
    input  logic                       align_left,
    input  logic [RES_W-1:0]           result_in,
    output logic                       busy,
    output logic                       sampling,
    output logic                       converting,
    output logic [CH_W-1:0]            conv_ch,
    output logic                       conv_inj,
    output logic                       eoc,
    output logic [OUT_W-1:0]           data_out
);

    localparam int TOP_CNT = (MAX_SMP_HALF > CONV_HALF) ? MAX_SMP_HALF : CONV_HALF;
    localparam int CNT_W   = $clog2(TOP_CNT + 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [CH_W-1:0]  ch;
        logic             inj;
        logic             left;
        logic             eoc;
        logic [OUT_W-1:0] data;
    } seq_t;

    seq_t q, d;

    logic [NUM_EVT-1:0]    rise;
    logic                  reg_go, inj_go;
    logic [CH_W-1:0]       start_ch;
    logic [SMP_CODE_W-1:0] start_code;
    logic [CNT_W-1:0]      start_len;
    logic [OUT_W-1:0]      fmt_word;

    adc_trig_sync #(
        .NUM_EVT    (NUM_EVT),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_in(evt_in),
        .rise  (rise)
    );

    assign reg_go     = sw_start_reg | (ext_trig_en & rise[reg_sel]);
    assign inj_go     = sw_start_inj | (ext_trig_en & rise[inj_sel]);
    assign start_ch   = inj_go ? ch_inj : ch_reg;
    assign start_code = smp_codes[start_ch*SMP_CODE_W +: SMP_CODE_W];

    adc_smp_lut #(.CNT_W(CNT_W)) u_lut (
        .code    (start_code),
        .half_cnt(start_len)
    );

    adc_result_fmt #(.RES_W(RES_W), .OUT_W(OUT_W)) u_fmt (
        .raw (result_in),
        .inj (q.inj),
        .left(q.left),
        .word(fmt_word)
    );

    always_comb begin
        d     = q;
        d.eoc = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (inj_go || reg_go) begin
                    d.state = ST_SAMPLE;
                    d.inj   = inj_go;
                    d.ch    = start_ch;
                    d.left  = align_left;
                    d.cnt   = start_len - CNT_W'(1);
                end
            end
            ST_SAMPLE: begin
                if (q.cnt == '0) begin
                    d.state = ST_CONV;
                    d.cnt   = CNT_W'(CONV_HALF - 1);
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_CONV: begin
                if (q.cnt == '0) begin
                    d.state = ST_IDLE;
                    d.eoc   = 1'b1;
                    d.data  = fmt_word;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cnt: '0, ch: '0, inj: 1'b0,
                   left: 1'b0, eoc: 1'b0, data: '0};
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.state != ST_IDLE);
    assign sampling   = (q.state == ST_SAMPLE);
    assign converting = (q.state == ST_CONV);
    assign conv_ch    = q.ch;
    assign conv_inj   = q.inj;
    assign eoc        = q.eoc;
    assign data_out   = q.data;

endmodule

// File: rtl/adc_conv_sequencer_chk.sv
module adc_conv_sequencer_chk #(
    parameter int CH_W  = 3,
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_trig_en,
    input logic             sw_start_reg,
    input logic             sw_start_inj,
    input logic             busy,
    input logic             sampling,
    input logic             converting,
    input logic [CH_W-1:0]  conv_ch,
    input logic             eoc,
    input logic [OUT_W-1:0] data_out
);

    assert_eoc_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc);

    assert_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc |-> $stable(data_out));

    assert_conv_after_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sampling) |-> converting);

    assert_eoc_after_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(converting) |-> eoc);

    assert_phases_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(sampling && converting));

    assert_no_ext_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ext_trig_en && !sw_start_reg && !sw_start_inj) |=> !busy);

    assert_channel_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(conv_ch));

endmodule

bind adc_conv_sequencer adc_conv_sequencer_chk #(
    .CH_W (CH_W),
    .OUT_W(OUT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_trig_en (ext_trig_en),
    .sw_start_reg(sw_start_reg),
    .sw_start_inj(sw_start_inj),
    .busy        (busy),
    .sampling    (sampling),
    .converting  (converting),
    .conv_ch     (conv_ch),
    .eoc         (eoc),
    .data_out    (data_out)
);

// File: tb/adc_conv_sequencer_test.sv
module adc_conv_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] smp_codes = '0;
    logic        ext_trig_en = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [2:0]  inj_sel = '0;
    logic [7:0]  evt_in = '0;
    logic        sw_start_reg = 1'b0;
    logic        sw_start_inj = 1'b0;
    logic [2:0]  ch_reg = '0;
    logic [2:0]  ch_inj = '0;
    logic        align_left = 1'b0;
    logic [11:0] result_in = '0;
    logic        busy, sampling, converting, conv_inj, eoc;
    logic [2:0]  conv_ch;
    logic [15:0] data_out;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    adc_conv_sequencer uut (
        .clk(clk), .rst_n(rst_n), .smp_codes(smp_codes), .ext_trig_en(ext_trig_en),
        .reg_sel(reg_sel), .inj_sel(inj_sel), .evt_in(evt_in),
        .sw_start_reg(sw_start_reg), .sw_start_inj(sw_start_inj),
        .ch_reg(ch_reg), .ch_inj(ch_inj), .align_left(align_left),
        .result_in(result_in), .busy(busy), .sampling(sampling),
        .converting(converting), .conv_ch(conv_ch), .conv_inj(conv_inj),
        .eoc(eoc), .data_out(data_out)
    );

    // code[3] inj[1] left[1] result[12] expected[16]
    localparam logic [32:0] VEC [8] = '{
        {3'd0, 1'b0, 1'b0, 12'hABC, 16'h0ABC},
        {3'd1, 1'b0, 1'b1, 12'h123, 16'h1230},
        {3'd2, 1'b1, 1'b0, 12'h8F0, 16'hF8F0},
        {3'd3, 1'b1, 1'b1, 12'h7FF, 16'h3FF8},
        {3'd7, 1'b0, 1'b0, 12'hFFF, 16'h0FFF},
        {3'd4, 1'b1, 1'b1, 12'h801, 16'hC008},
        {3'd5, 1'b0, 1'b1, 12'hFFF, 16'hFFF0},
        {3'd6, 1'b1, 1'b0, 12'h000, 16'h0000}
    };

    function automatic int exp_smp(input logic [2:0] code);
        case (code)
            3'd0: return 3;    3'd1: return 15;
            3'd2: return 27;   3'd3: return 57;
            3'd4: return 83;   3'd5: return 111;
            3'd6: return 143;  default: return 479;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // Called at the negedge right after a start was accepted
    task automatic measure(input string tag, input int smp, input logic inj,
                           input logic [15:0] exp_data);
        int ns = 0;
        int nc = 0;
        while (sampling) begin ns++; @(negedge clk); end
        while (converting) begin nc++; @(negedge clk); end
        chk(ns == smp, "R1 sample length", ns, smp);
        chk(nc == 25, "R2 conversion length", nc, 25);
        chk(eoc == 1'b1, "R2 eoc after conversion", eoc, 1);
        chk(conv_inj == inj, "R12 group", conv_inj, inj);
        chk(data_out == exp_data, tag, data_out, exp_data);
        @(negedge clk);
        chk(eoc == 1'b0 && data_out == exp_data, "R11 eoc single and data held", eoc, 0);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !sampling && !converting && !eoc && data_out == 0,
            "R13 reset state", data_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !eoc && data_out == 0, "R13 after reset", busy, 0);

        // Table walk: each code with a group/alignment pair, software started
        for (int i = 0; i < 8; i++) begin
            logic [2:0] code;
            logic inj, left;
            logic [15:0] expw;
            string tag;
            {code, inj, left, result_in, expw} = VEC[i];
            smp_codes = '0;
            smp_codes[i*3 +: 3] = code;
            ch_reg = 3'(i);
            ch_inj = 3'(i);
            align_left = left;
            case ({inj, left})
                2'b00: tag = "R7 regular right";
                2'b01: tag = "R8 regular left";
                2'b10: tag = "R9 injected right";
                default: tag = "R10 injected left";
            endcase
            if (inj) sw_start_inj = 1'b1; else sw_start_reg = 1'b1;
            @(negedge clk);
            sw_start_inj = 1'b0;
            sw_start_reg = 1'b0;
            chk(sampling && conv_ch == 3'(i), "R12 software start", conv_ch, i);
            measure(tag, exp_smp(code), inj, expw);
        end

        // External trigger, regular group on line 5, code 0 on channel 1
        smp_codes = '0;
        ch_reg = 3'd1;
        ch_inj = 3'd2;
        align_left = 1'b0;
        result_in = 12'h5A5;
        reg_sel = 3'd5;
        inj_sel = 3'd2;
        ext_trig_en = 1'b1;
        evt_in[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!sampling, "R4 no start before third edge", sampling, 0);
        @(negedge clk);
        chk(sampling && !conv_inj && conv_ch == 3'd1, "R4 regular event start", sampling, 1);
        measure("R7 event result", 3, 1'b0, 16'h05A5);
        repeat (40) @(negedge clk);
        chk(!busy, "R5 held level no retrigger", busy, 0);
        evt_in[5] = 1'b0;
        repeat (10) @(negedge clk);
        chk(!busy, "R5 falling edge ignored", busy, 0);

        // Trigger disabled
        ext_trig_en = 1'b0;
        evt_in[5] = 1'b1;
        evt_in[2] = 1'b1;
        repeat (10) @(negedge clk);
        chk(!busy, "R3 disabled events ignored", busy, 0);
        evt_in = '0;
        repeat (5) @(negedge clk);

        // Injected selector, then a regular event during busy
        ext_trig_en = 1'b1;
        smp_codes[2*3 +: 3] = 3'd1;
        evt_in[2] = 1'b1;
        repeat (3) @(negedge clk);
        chk(sampling && conv_inj && conv_ch == 3'd2, "R4 injected event start", conv_inj, 1);
        evt_in[5] = 1'b1;
        sw_start_reg = 1'b1;
        @(negedge clk);
        sw_start_reg = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy && conv_ch == 3'd2 && conv_inj, "R6 trigger while busy dropped", conv_ch, 2);
        wait_idle();
        repeat (10) @(negedge clk);
        chk(!busy, "R6 no queued start", busy, 0);
        evt_in = '0;
        ext_trig_en = 1'b0;
        repeat (5) @(negedge clk);

        // Simultaneous software starts: injected wins
        ch_reg = 3'd4;
        ch_inj = 3'd6;
        sw_start_reg = 1'b1;
        sw_start_inj = 1'b1;
        @(negedge clk);
        sw_start_reg = 1'b0;
        sw_start_inj = 1'b0;
        chk(conv_inj && conv_ch == 3'd6, "R12 injected priority", conv_ch, 6);
        wait_idle();

        finish_run();
    end

endmodule